// File: doc/BRIEF.md
# TDM Time-Slot Interchange Switch

This block moves byte samples between serial time-division lines. Every input line carries one bit per clock cycle. Eight cycles make one byte slot, sent most significant bit first, and `2**SLOT_W` slots make one frame. The block shifts in every input line and stores each completed byte in a speech memory. The memory has two halves that swap at every frame boundary: one half collects the current frame while the other half supplies the frame before it.

Each output line has a connection table with one entry per slot. At the end of input slot `s`, every output loads the byte named by its entry for slot `s` from the previous frame's half. It then shifts that byte out during the next eight cycles. Any stored channel can therefore reach any output slot, and one channel may feed several outputs.

An output slot can be floated, which shows as its enable being low. A slot floats when its entry carries a tristate flag, or when a control input reserves the all-zero source address for that purpose. A standby input floats every output while the switching keeps running. Reset aligns the frame: the first cycle after reset is bit 0 of slot 0 of frame 0.

Top module: `tsi_switch`

## Requirements
- R1: While reset is held, and during the first seven cycles after it, every `serOe` and `serOut` bit is low.
- R2: Input bit `k` (0..7) of a slot is bit `7-k` of the stored byte, so the MSB comes first.
- R3: Output line `o` in slot `s` of frame `f+1` carries the byte received in frame `f` on the line and slot named by the entry for (`o`,`s`). The entry layout is: top bit is the tristate flag, the next `$clog2(N_IN)` bits are the source line, and the low `SLOT_W` bits are the source slot.
- R4: Output slot `s` takes up the eight cycles right after input slot `s` ends, MSB first. Its enable holds steady across those eight cycles unless standby changes.
- R5: A frame is `8*2**SLOT_W` cycles long. The write half of the speech memory flips exactly once per frame, so input data from the current frame never appears in the current frame's output.
- R6: An entry with the tristate flag set gives a low enable and a low data bit for that output slot. A line whose enable is low always drives data low.
- R7: With `zeroTriEn` high at the slot load, a source address of all zeros (line 0, slot 0) floats the slot. With `zeroTriEn` low, that address routes line 0 slot 0 like any other source.
- R8: While `standby` is high, every enable and data bit is low. Loading and switching carry on, so the correct data returns on the cycle standby drops.
- R9: A connection entry written at a clock edge is used by every slot load at a later edge. A load at that same edge still sees the old entry.
- R10: Any of the `N_IN*2**SLOT_W` sources can be routed to any output slot, including the same source to several outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one bit per line per cycle |
| rst | input | 1 | Synchronous active-high reset; aligns the frame |
| serIn | input | N_IN | Serial input lines |
| standby | input | 1 | Floats all outputs while switching continues |
| zeroTriEn | input | 1 | Makes the all-zero source address mean "float" |
| cmWe | input | 1 | Connection entry write strobe |
| cmLine | input | $clog2(N_OUT) | Output line of the entry written |
| cmSlot | input | SLOT_W | Output slot of the entry written |
| cmEntry | input | 1+$clog2(N_IN)+SLOT_W | Entry value: {flag, source line, source slot} |
| serOut | output | N_OUT | Serial output data; low when not enabled |
| serOe | output | N_OUT | Output enable per line; low means high impedance |

## Verification
The bench builds the switch with four input lines, four output lines and eight slots per frame. In this size one frame is only 64 cycles, and all 32 sources can be rotated through every output slot across a few frames. The bench rewrites entries in the middle of a frame, so both old and new entries are seen at the load edges. It checks the all-zero address with the control bit high and low, the tristate flag, and standby windows that open and close inside a slot. Every output bit of every cycle is compared against an arithmetic model of the data pattern.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  // Strobes from the frame sequencer to the datapath
  typedef struct packed {
    logic slotEnd;  // last bit period of the current slot
    logic wrHalf;   // speech memory half being written this frame
  } tsiStrobes_t;
endpackage

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  output tsiStrobes_t       strb,
  output logic [SLOT_W-1:0] slotIdx
);
  logic [2:0]        bitCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic              half;
  logic              lastBit;

  assign lastBit = (bitCnt == 3'd7);

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt  <= '0;
      slotCnt <= '0;
      half    <= 1'b0;
    end else begin
      bitCnt <= bitCnt + 3'd1;
      if (lastBit) begin
        slotCnt <= slotCnt + 1'b1;
        if (&slotCnt) half <= ~half;
      end
    end
  end

  assign strb.slotEnd = lastBit;
  assign strb.wrHalf  = half;
  assign slotIdx      = slotCnt;
endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath
  import tsi_pkg::*;
#(
  parameter int N_IN   = 16,
  parameter int N_OUT  = 8,
  parameter int SLOT_W = 5
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  tsiStrobes_t                            strb,
  input  logic [SLOT_W-1:0]                      slotIdx,
  input  logic [N_IN-1:0]                        serIn,
  input  logic                                   standby,
  input  logic                                   zeroTriEn,
  input  logic                                   cmWe,
  input  logic [$clog2(N_OUT)-1:0]               cmLine,
  input  logic [SLOT_W-1:0]                      cmSlot,
  input  logic [SLOT_W+$clog2(N_IN):0]           cmEntry,
  output logic [N_OUT-1:0]                       serOut,
  output logic [N_OUT-1:0]                       serOe
);
  localparam int SLOTS   = 1 << SLOT_W;
  localparam int LINE_W  = $clog2(N_IN);
  localparam int OUT_W   = $clog2(N_OUT);
  localparam int ENTRY_W = 1 + LINE_W + SLOT_W;

  logic [ENTRY_W-1:0] cm [N_OUT*SLOTS];
  logic [7:0]         rdMat [N_IN][N_OUT];
  logic [SLOT_W-1:0]  srcSlotV [N_OUT];

  // Connection memory: one entry per output slot
  always_ff @(posedge clk) begin
    if (cmWe) cm[{cmLine, cmSlot}] <= cmEntry;
  end

  // Input capture and speech memory, one bank per input line
  for (genvar l = 0; l < N_IN; l++) begin : g_line
    logic [6:0] shiftReg;
    logic [7:0] mem [2*SLOTS];

    always_ff @(posedge clk) begin
      shiftReg <= {shiftReg[5:0], serIn[l]};
      if (strb.slotEnd) mem[{strb.wrHalf, slotIdx}] <= {shiftReg, serIn[l]};
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_rd
      assign rdMat[l][o] = mem[{~strb.wrHalf, srcSlotV[o]}];
    end
  end

  // Slot load and parallel-to-serial output, one per output line
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [ENTRY_W-1:0] ent;
    logic               hiZ;
    logic [LINE_W-1:0]  srcLine;
    logic               zeroAddr;
    logic               floatSlot;
    logic [7:0]         outShift;
    logic               oeReg;

    assign ent         = cm[{OUT_W'(o), slotIdx}];
    assign hiZ         = ent[ENTRY_W-1];
    assign srcLine     = ent[ENTRY_W-2:SLOT_W];
    assign srcSlotV[o] = ent[SLOT_W-1:0];
    assign zeroAddr    = (ent[ENTRY_W-2:0] == '0);
    assign floatSlot   = hiZ | (zeroTriEn & zeroAddr);

    always_ff @(posedge clk) begin
      if (rst) begin
        outShift <= '0;
        oeReg    <= 1'b0;
      end else if (strb.slotEnd) begin
        outShift <= rdMat[srcLine][o];
        oeReg    <= ~floatSlot;
      end else begin
        outShift <= {outShift[6:0], 1'b0};
      end
    end

    assign serOe[o]  = oeReg & ~standby;
    assign serOut[o] = outShift[7] & oeReg & ~standby;
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter int N_IN   = 16,
  parameter int N_OUT  = 8,
  parameter int SLOT_W = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_IN-1:0]               serIn,
  input  logic                          standby,
  input  logic                          zeroTriEn,
  input  logic                          cmWe,
  input  logic [$clog2(N_OUT)-1:0]      cmLine,
  input  logic [SLOT_W-1:0]             cmSlot,
  input  logic [SLOT_W+$clog2(N_IN):0]  cmEntry,
  output logic [N_OUT-1:0]              serOut,
  output logic [N_OUT-1:0]              serOe
);
  tsiStrobes_t       strb;
  logic [SLOT_W-1:0] slotIdx;

  tsi_ctrl #(.SLOT_W(SLOT_W)) u_ctrl (
    .clk(clk), .rst(rst), .strb(strb), .slotIdx(slotIdx)
  );

  tsi_datapath #(.N_IN(N_IN), .N_OUT(N_OUT), .SLOT_W(SLOT_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .slotIdx(slotIdx),
    .serIn(serIn), .standby(standby), .zeroTriEn(zeroTriEn),
    .cmWe(cmWe), .cmLine(cmLine), .cmSlot(cmSlot), .cmEntry(cmEntry),
    .serOut(serOut), .serOe(serOe)
  );
endmodule

// File: rtl/tsi_switch_chk.sv
module tsi_switch_chk
  import tsi_pkg::*;
#(
  parameter int N_OUT  = 8,
  parameter int SLOT_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              standby,
  input logic [N_OUT-1:0]  serOut,
  input logic [N_OUT-1:0]  serOe,
  input tsiStrobes_t       strb,
  input logic [SLOT_W-1:0] slotIdx
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (serOe == '0)); // R1

  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (rst)
    standby |-> (serOe == '0 && serOut == '0)); // R8

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    (serOut & ~serOe) == '0); // R6

  AST_OE_SLOT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(strb.slotEnd) && $stable(standby)) |-> $stable(serOe)); // R4

  AST_SLOT_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    $past(strb.slotEnd) |-> (slotIdx == SLOT_W'($past(slotIdx) + 1'b1))); // R4

  AST_HALF_FLIP: assert property (@(posedge clk) disable iff (rst)
    $past(strb.slotEnd && (&slotIdx)) |-> (strb.wrHalf != $past(strb.wrHalf))); // R5

  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(strb.slotEnd && (&slotIdx)) |-> $stable(strb.wrHalf)); // R5
endmodule

bind tsi_switch tsi_switch_chk #(.N_OUT(N_OUT), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst(rst), .standby(standby), .serOut(serOut), .serOe(serOe),
  .strb(strb), .slotIdx(slotIdx)
);

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb;
  localparam int N_IN   = 4;
  localparam int N_OUT  = 4;
  localparam int SLOT_W = 3;
  localparam int SLOTS  = 1 << SLOT_W;
  localparam int FRAME  = 8 * SLOTS;
  localparam int NSRC   = N_IN * SLOTS;
  localparam int LW     = $clog2(N_IN);
  localparam int EW     = 1 + LW + SLOT_W;
  localparam int NFRAMES = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N_IN-1:0] serIn = '0;
  logic standby = 1'b0;
  logic zeroTriEn = 1'b0;
  logic cmWe = 1'b0;
  logic [$clog2(N_OUT)-1:0] cmLine = '0;
  logic [SLOT_W-1:0] cmSlot = '0;
  logic [EW-1:0] cmEntry = '0;
  logic [N_OUT-1:0] serOut;
  logic [N_OUT-1:0] serOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [EW-1:0] modelCm [N_OUT][SLOTS];
  logic [7:0] expByte [N_OUT];
  logic       expOe [N_OUT];
  logic       expValid [N_OUT];
  string      expTag [N_OUT];

  always #4 clk = ~clk;

  tsi_switch #(.N_IN(N_IN), .N_OUT(N_OUT), .SLOT_W(SLOT_W)) u_dut (
    .clk(clk), .rst(rst), .serIn(serIn), .standby(standby), .zeroTriEn(zeroTriEn),
    .cmWe(cmWe), .cmLine(cmLine), .cmSlot(cmSlot), .cmEntry(cmEntry),
    .serOut(serOut), .serOe(serOe)
  );

  function automatic logic [7:0] dataOf(int f, int l, int t);
    int v;
    v = f * 73 + l * 29 + t * 11 + 5;
    return v[7:0];
  endfunction

  // Entry planned for frame f: rotating source, optional tristate flag
  function automatic logic [EW-1:0] planEntry(int f, int o, int s);
    int src;
    logic hz;
    src = (o * SLOTS + s + f * 5) % NSRC;
    hz  = (f >= 6 && f < 9) && (((o * SLOTS + s + f) % 5) == 2);
    return {hz, src[LW+SLOT_W-1:0]};
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at negedge, model load edge, sample at next negedge
  task automatic stepCycle(int cc);
    int f, p, b, slot;
    int wo, ws;
    logic doWr;
    f = cc / FRAME;
    p = cc % FRAME;
    slot = p / 8;
    b = p % 8;
    for (int l = 0; l < N_IN; l++) serIn[l] = dataOf(f, l, slot)[7 - b];   // R2
    zeroTriEn = (f >= 9 && f < 12);
    standby = (f >= 12 && f < 14) && (p >= 20 && p < 50);
    doWr = (p < N_OUT * SLOTS);
    wo = p / SLOTS;
    ws = p % SLOTS;
    cmWe = doWr;
    if (doWr) begin
      cmLine = wo[$clog2(N_OUT)-1:0];
      cmSlot = ws[SLOT_W-1:0];
      cmEntry = planEntry(f + 1, wo, ws);
    end
    // R9: a load at this edge uses the entries as they stand before this write
    if (b == 7) begin
      for (int o = 0; o < N_OUT; o++) begin
        logic [EW-1:0] e;
        logic zero;
        e = modelCm[o][slot];
        zero = (e[EW-2:0] == '0);
        expValid[o] = (f >= 1);
        expByte[o] = dataOf(f - 1, int'(e[EW-2:SLOT_W]), int'(e[SLOT_W-1:0]));
        if (e[EW-1]) begin
          expOe[o] = 1'b0; expTag[o] = "R6";
        end else if (zeroTriEn && zero) begin
          expOe[o] = 1'b0; expTag[o] = "R7";
        end else begin
          expOe[o] = 1'b1;
          expTag[o] = zero ? "R7 R3" : "R3 R4 R5 R10";
        end
      end
    end
    @(posedge clk);
    if (doWr) modelCm[wo][ws] = planEntry(f + 1, wo, ws);
    @(negedge clk);
    for (int o = 0; o < N_OUT; o++) begin
      logic eo, ed;
      int k;
      k = (cc + 1) % 8;
      eo = expOe[o] & ~standby;
      ed = eo & expByte[o][7 - k];
      if (standby) begin
        check("R8 enable", int'(serOe[o]), 0);
        check("R8 data", int'(serOut[o]), 0);
      end else begin
        check({expTag[o], " enable"}, int'(serOe[o]), int'(eo));
        if (!eo) check({expTag[o], " quiet data"}, int'(serOut[o]), 0);
        else if (expValid[o]) check({expTag[o], " R2 data"}, int'(serOut[o]), int'(ed));
      end
    end
  endtask

  initial begin
    for (int o = 0; o < N_OUT; o++) begin
      expByte[o] = '0; expOe[o] = 1'b0; expValid[o] = 1'b0; expTag[o] = "R1";
    end
    rst = 1'b1;
    // Program frame 0 connections during reset
    for (int i = 0; i < N_OUT * SLOTS; i++) begin
      @(negedge clk);
      cmWe = 1'b1;
      cmLine = i[$clog2(N_OUT)+SLOT_W-1:SLOT_W];
      cmSlot = i[SLOT_W-1:0];
      cmEntry = planEntry(0, i / SLOTS, i % SLOTS);
      modelCm[i / SLOTS][i % SLOTS] = planEntry(0, i / SLOTS, i % SLOTS);
    end
    @(negedge clk);
    cmWe = 1'b0;
    @(negedge clk);
    check("R1 reset enable", int'(serOe), 0);
    check("R1 reset data", int'(serOut), 0);
    rst = 1'b0;
    for (int cc = 0; cc < NFRAMES * FRAME; cc++) stepCycle(cc);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule